// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Hazard Stall Control

This block is the hazard controller for a five-stage in-order pipeline (fetch, decode with register read, execute, memory, writeback). It is purely combinational. Each cycle it compares register numbers held in the pipeline latches. It then picks the source of each of the two ALU operands and decides whether the instruction in decode must be held back.

Two sets of comparisons are made. The source registers of the instruction entering execute are compared with the destination registers in the execute/memory and memory/writeback latches. These comparisons steer the operand multiplexers. The source registers of the instruction in decode are compared with the destination of the instruction entering execute. When that instruction is a load, its data cannot arrive in time. The block then asks the pipeline to freeze the PC and the fetch/decode latch, and to load a bubble (write-enable cleared) into the decode/execute latch.

A parameter builds a variant without forwarding. In that variant the operand selects stay on the register file. A consumer waits in decode until its producer reaches writeback. The register file writes in the first half of a cycle and reads in the second half, so a consumer and its producer in writeback can share a cycle.

Top module: `hz_fwd_ctrl`

## Requirements
- R1: Each operand select takes only the codes 2'b00 (register file value), 2'b10 (execute/memory latch result) or 2'b01 (memory/writeback latch value). The code 2'b11 never appears.
- R2: With forwarding on, an operand whose source register equals the execute/memory destination selects 2'b10.
- R3: With forwarding on, an operand that matches only the memory/writeback destination selects 2'b01. An operand with no match selects 2'b00.
- R4: When both the execute/memory and the memory/writeback destinations match an operand, the execute/memory (younger) value wins with 2'b10.
- R5: A destination of register 0, or a stage whose write-enable is low, never causes a forward or a stall.
- R6: With forwarding on, a load in the decode/execute latch whose destination equals either decode source asserts the hold and the bubble in the same cycle.
- R7: With forwarding on, a non-load producer in the decode/execute latch causes no stall. Producers in the execute/memory or memory/writeback latches cause no stall.
- R8: With forwarding off, both selects are always 2'b00. The block stalls whenever a decode source matches the destination in the decode/execute latch or in the execute/memory latch, whether or not the producer is a load.
- R9: In either mode, a match against the memory/writeback destination alone never stalls.
- R10: The hold and the bubble outputs are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs1 | input | REG_W | First source register of the instruction in decode |
| dec_rs2 | input | REG_W | Second source register of the instruction in decode |
| ex_rs1 | input | REG_W | First source register held in the decode/execute latch |
| ex_rs2 | input | REG_W | Second source register held in the decode/execute latch |
| ex_rd | input | REG_W | Destination held in the decode/execute latch |
| ex_we | input | 1 | Register write-enable in the decode/execute latch |
| ex_load | input | 1 | Instruction in the decode/execute latch is a load |
| mem_rd | input | REG_W | Destination held in the execute/memory latch |
| mem_we | input | 1 | Register write-enable in the execute/memory latch |
| wb_rd | input | REG_W | Destination held in the memory/writeback latch |
| wb_we | input | 1 | Register write-enable in the memory/writeback latch |
| sel_a | output | 2 | Source select for the first ALU operand |
| sel_b | output | 2 | Source select for the second ALU operand |
| hold_front | output | 1 | Freeze the PC and the fetch/decode latch |
| bubble | output | 1 | Load a no-op with write-enable cleared into the decode/execute latch |

## Verification
The bench sweeps every combination of source and destination registers with a 3-bit register number, over every write-enable and load flag setting, on both the forwarding and the no-forwarding variants. It targets these cases and their failure symptoms:
- Both forwarding latches match the same operand. A design with the priority reversed would feed the older value and select 2'b01.
- A destination of register 0, or a cleared write-enable. A design that skips either check would forward stale data or stall for no reason.
- A load producer versus an ALU producer. A design that stalls on every producer loses throughput; one that ignores the load flag feeds garbage.
- A producer in writeback with forwarding off. A design that ignores the split-cycle register file would add a third bubble.

// File: rtl/hz_fwd_pkg.sv
package hz_fwd_pkg;

  // Operand source codes driven onto the ALU input multiplexers
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } opnd_src_e;

  // Widest register number the helpers accept
  localparam int unsigned MAX_REG_W = 8;

  // A latch supplies a register only if it writes, targets a real register
  // and the numbers agree.
  function automatic logic dest_hits(input logic                 we,
                                     input logic [MAX_REG_W-1:0] rd,
                                     input logic [MAX_REG_W-1:0] rs);
    return we && (rd != '0) && (rd == rs);
  endfunction

  // Younger producer first, then the older one, else the register file.
  function automatic opnd_src_e pick_src(input logic mem_hit,
                                         input logic wb_hit);
    if (mem_hit)     return SRC_MEM;
    else if (wb_hit) return SRC_WB;
    else             return SRC_RF;
  endfunction

endpackage

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
  import hz_fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic [REG_W-1:0] src,
  input  logic             mem_we,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             wb_we,
  input  logic [REG_W-1:0] wb_rd,
  output opnd_src_e        sel,
  output logic             mem_hit,
  output logic             wb_hit
);

  assign mem_hit = dest_hits(mem_we, MAX_REG_W'(mem_rd), MAX_REG_W'(src));
  assign wb_hit  = dest_hits(wb_we,  MAX_REG_W'(wb_rd),  MAX_REG_W'(src));

  generate
    if (FWD_EN) begin : g_fwd
      assign sel = pick_src(mem_hit, wb_hit);
    end else begin : g_nofwd
      assign sel = SRC_RF;
    end
  endgenerate

endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect
  import hz_fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  output logic             ex_dep,
  output logic             mem_dep,
  output logic             load_use,
  output logic             stall
);

  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic [NSRC-1:0]            ex_hit;
  logic [NSRC-1:0]            mem_hit;

  assign srcs[0] = dec_rs1;
  assign srcs[1] = dec_rs2;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign ex_hit[i]  = dest_hits(ex_we,  MAX_REG_W'(ex_rd),  MAX_REG_W'(srcs[i]));
    assign mem_hit[i] = dest_hits(mem_we, MAX_REG_W'(mem_rd), MAX_REG_W'(srcs[i]));
  end

  assign ex_dep   = |ex_hit;
  assign mem_dep  = |mem_hit;
  assign load_use = ex_dep && ex_load;

  generate
    if (FWD_EN) begin : g_fwd
      assign stall = load_use;
    end else begin : g_nofwd
      // The writeback latch is read back in the same cycle, so only
      // the two younger producers force a wait.
      assign stall = ex_dep || mem_dep;
    end
  endgenerate

endmodule

// File: rtl/hz_fwd_ctrl.sv
module hz_fwd_ctrl
  import hz_fwd_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             hold_front,
  output logic             bubble
);

  localparam int unsigned NOPND = 2;

  logic [NOPND-1:0][REG_W-1:0] opnd_src;
  opnd_src_e [NOPND-1:0]       opnd_sel;
  logic [NOPND-1:0]            fwd_mem_hit;
  logic [NOPND-1:0]            fwd_wb_hit;

  logic ex_dep, mem_dep, load_use, stall;

  assign opnd_src[0] = ex_rs1;
  assign opnd_src[1] = ex_rs2;

  for (genvar k = 0; k < NOPND; k++) begin : g_opnd
    hz_operand_sel #(.REG_W(REG_W), .FWD_EN(FWD_EN)) u_sel (
      .src     (opnd_src[k]),
      .mem_we  (mem_we),
      .mem_rd  (mem_rd),
      .wb_we   (wb_we),
      .wb_rd   (wb_rd),
      .sel     (opnd_sel[k]),
      .mem_hit (fwd_mem_hit[k]),
      .wb_hit  (fwd_wb_hit[k])
    );
  end

  hz_stall_detect #(.REG_W(REG_W), .FWD_EN(FWD_EN)) u_stall (
    .dec_rs1  (dec_rs1),
    .dec_rs2  (dec_rs2),
    .ex_rd    (ex_rd),
    .ex_we    (ex_we),
    .ex_load  (ex_load),
    .mem_rd   (mem_rd),
    .mem_we   (mem_we),
    .ex_dep   (ex_dep),
    .mem_dep  (mem_dep),
    .load_use (load_use),
    .stall    (stall)
  );

  assign sel_a      = opnd_sel[0];
  assign sel_b      = opnd_sel[1];
  assign hold_front = stall;
  assign bubble     = stall;

endmodule

// File: rtl/hz_fwd_ctrl_chk.sv
module hz_fwd_ctrl_chk #(
  parameter int unsigned REG_W  = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input logic [REG_W-1:0] dec_rs1,
  input logic [REG_W-1:0] dec_rs2,
  input logic [REG_W-1:0] ex_rs1,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_we,
  input logic             ex_load,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_we,
  input logic [REG_W-1:0] wb_rd,
  input logic             wb_we,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic             hold_front,
  input logic             bubble,
  input logic             load_use,
  input logic             mem_dep
);

  logic known;
  assign known = !$isunknown({dec_rs1, dec_rs2, ex_rs1, ex_rd, ex_we, ex_load,
                              mem_rd, mem_we, wb_rd, wb_we, sel_a, sel_b,
                              hold_front, bubble, load_use, mem_dep});

  always_comb begin
    if (known) begin
      // R1
      sel_code_legal_chk: assert (sel_a != 2'b11 && sel_b != 2'b11);
      // R4
      younger_wins_chk: assert (!(FWD_EN && mem_we && mem_rd != '0 &&
                                  mem_rd == ex_rs1) || sel_a == 2'b10);
      // R5
      zero_reg_chk: assert (ex_rs1 != '0 || sel_a == 2'b00);
      // R6
      load_use_hold_chk: assert (!(FWD_EN && load_use) || (hold_front && bubble));
      // R7
      alu_no_stall_chk: assert (!(FWD_EN && !ex_load) || !hold_front);
      // R8
      nofwd_rf_only_chk: assert (FWD_EN || (sel_a == 2'b00 && sel_b == 2'b00));
      // R8
      nofwd_mem_wait_chk: assert (FWD_EN || !mem_dep || hold_front);
      // R9
      wb_no_stall_chk: assert (!(wb_we && wb_rd == dec_rs1 && wb_rd == dec_rs2 &&
                                 !ex_we && !mem_we) || !hold_front);
      // R10
      hold_bubble_eq_chk: assert (hold_front == bubble);
    end
  end

endmodule

bind hz_fwd_ctrl hz_fwd_ctrl_chk #(.REG_W(REG_W), .FWD_EN(FWD_EN)) u_chk (
  .dec_rs1    (dec_rs1),
  .dec_rs2    (dec_rs2),
  .ex_rs1     (ex_rs1),
  .ex_rd      (ex_rd),
  .ex_we      (ex_we),
  .ex_load    (ex_load),
  .mem_rd     (mem_rd),
  .mem_we     (mem_we),
  .wb_rd      (wb_rd),
  .wb_we      (wb_we),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .hold_front (hold_front),
  .bubble     (bubble),
  .load_use   (load_use),
  .mem_dep    (mem_dep)
);

// File: tb/sim_hz_fwd_ctrl.sv
module sim_hz_fwd_ctrl;

  localparam int unsigned RW = 3;
  localparam int unsigned NR = 1 << RW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [RW-1:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic          ex_we, ex_load, mem_we, wb_we;
  logic [1:0]    sel_a0, sel_b0, sel_a1, sel_b1;
  logic          hold0, bub0, hold1, bub1;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  hz_fwd_ctrl #(.REG_W(RW), .FWD_EN(1'b1)) u0 (
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load), .mem_rd(mem_rd),
    .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .sel_a(sel_a0), .sel_b(sel_b0), .hold_front(hold0), .bubble(bub0));

  hz_fwd_ctrl #(.REG_W(RW), .FWD_EN(1'b0)) u1 (
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load), .mem_rd(mem_rd),
    .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .sel_a(sel_a1), .sel_b(sel_b1), .hold_front(hold1), .bubble(bub1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected select: code 2 for the younger latch, 1 for the older, 0 otherwise
  function automatic int exp_sel(input int s);
    int m, w;
    m = (mem_we && mem_rd != 0 && int'(mem_rd) == s) ? 2 : 0;
    w = (wb_we && wb_rd != 0 && int'(wb_rd) == s) ? 1 : 0;
    return (m != 0) ? m : w;
  endfunction

  function automatic int reads(input int rd);
    return (rd != 0 && (int'(dec_rs1) == rd || int'(dec_rs2) == rd)) ? 1 : 0;
  endfunction

  task automatic apply;
    @(negedge clk);
    #1;
  endtask

  initial begin
    {dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {ex_we, ex_load, mem_we, wb_we} = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Idle pipeline: everything points at the register file, no stall (R1, R10)
    apply();
    chk("R1 idle sel_a", sel_a0, 0);
    chk("R1 idle sel_b", sel_b0, 0);
    chk("R10 idle hold", hold0, 0);
    chk("R10 idle bubble", bub0, 0);

    // Sweep of operand selects: all source/destination pairs, all enables
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++)
        for (int m = 0; m < NR; m++)
          for (int w = 0; w < NR; w++)
            for (int e = 0; e < 4; e++) begin
              ex_rs1 = RW'(a); ex_rs2 = RW'(b);
              mem_rd = RW'(m); wb_rd = RW'(w);
              mem_we = e[0];   wb_we = e[1];
              ex_we = 1'b0;    ex_load = 1'b0;
              apply();
              // R2 R3 R4 R5: forwarding priority and register-0 / enable gating
              chk("R2_R3_R4_R5 sel_a", sel_a0, exp_sel(a));
              chk("R2_R3_R4_R5 sel_b", sel_b0, exp_sel(b));
              // R8: no forwarding variant keeps the register file
              chk("R8 nofwd sel_a", sel_a1, 0);
              chk("R8 nofwd sel_b", sel_b1, 0);
            end

    // Sweep of stall decisions
    ex_rs1 = '0; ex_rs2 = '0;
    for (int r1 = 0; r1 < NR; r1++)
      for (int r2 = 0; r2 < NR; r2++)
        for (int xd = 0; xd < NR; xd++)
          for (int md = 0; md < NR; md++)
            for (int f = 0; f < 8; f++) begin
              int exp_f, exp_n;
              dec_rs1 = RW'(r1); dec_rs2 = RW'(r2);
              ex_rd = RW'(xd);   mem_rd = RW'(md);
              ex_we = f[0]; ex_load = f[1]; mem_we = f[2];
              // producer in writeback always matches the first source (R9)
              wb_rd = RW'(r1); wb_we = 1'b1;
              apply();
              exp_f = (ex_we && ex_load) ? reads(xd) : 0;
              exp_n = ((ex_we && reads(xd) != 0) || (mem_we && reads(md) != 0)) ? 1 : 0;
              // R6 R7 R5 R9: forwarding variant stalls only on load-use
              chk("R6_R7_R9 fwd hold", hold0, exp_f);
              // R8 R9: no-forwarding variant waits out the two younger producers
              chk("R8_R9 nofwd hold", hold1, exp_n);
              // R10
              chk("R10 fwd bubble", bub0, hold0);
              chk("R10 nofwd bubble", bub1, hold1);
            end

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule